// File: doc/BRIEF.md
# Attachment Control Register Block

This block is the byte-wide register window that a host processor uses to steer a network adapter. Every host access carries a 9-bit address. The low five bits pick a byte register. The next two bits pick how the data byte is applied: a plain write, a bitwise AND into the register, a bitwise OR into the register, or a read. The top two bits pick an area: the control registers, a reserved area, a read-only area holding the adapter's node address, or a read-only area holding a test pattern. The AND and OR modes let the host clear or set single bits in one access, with no separate read beforehand.

The control area holds three pairs of registers. The first pair is the host interrupt status. The second is the doorbell pair, which is presented to the adapter. The third pair, together with a 16-bit down-counter, forms an interval timer. Event pulses from the adapter side set status bits. The host sets doorbell bits, and the adapter acknowledges them. One interrupt output and one channel-check output tell the host that an enabled status bit is pending.

Top module: `acr_regblock`

## Requirements
- R1: After a synchronous active-low reset, every control register and the timer count read 0x00, both interrupt outputs are low, `host_rdata` is 0x00, and the doorbell outputs are 0x00.
- R2: An access is a cycle with `host_sel` high. `host_addr[4:0]` is the register index and `host_addr[6:5]` the mode: 00 write, 01 AND-merge, 10 OR-merge, 11 read. `host_addr[8:7]` is the area: 00 control, 01 reserved, 10 node address, 11 test pattern. A write-type access updates the register at the clock edge that ends the access cycle.
- R3: The control-area indices and their implemented bits are as follows; unimplemented bits always read 0. Index 8 is host status low (mask 0xDF). Index 9 is host status high (0x7C). Index 10 is doorbell control (0xFB), driven on `db_ctl`. Index 11 is the doorbell request (0x3F). Index 12 is timer control (0x80). Index 13 is the timer prescale divisor (0xFF).
- R4: A high bit of `adp_set_e` within 0x1C, or of `adp_set_o` within 0x7C, sets the same bit of index 8 or index 9 at the next edge. It does so even when a host access to that register would clear the bit in the same cycle.
- R5: A write, AND or OR access to a control-area index outside 8..15, or to any other area, changes no register. Instead it sets bit 2 of index 8 (the access-error flag).
- R6: The status is pending when any of index 8 bits 4..2 or index 9 bits 6..2 is set. With index 8 bit 6 set, a pending status drives `host_irq` if index 8 bit 7 is 1, or drives `host_chck` if it is 0. With bit 6 clear, both outputs are low. The outputs follow the registers with no added delay.
- R7: Index 11 is driven on `db_req`. A high bit of `adp_ack` clears that doorbell bit at the next edge. The clear is applied before a host access in the same cycle, so a host OR-set of the bit in that cycle leaves it set.
- R8: A read returns data on `host_rdata` one cycle later, and the value holds until the next read. The control area returns the addressed register, or 0x00 for an unused index. The reserved area returns 0x00. The node area returns byte i of `NODE_ID` (most significant byte at index 0) for i < 6, and 0x00 otherwise. The pattern area returns `PAT_SEED ^ (i << 3)`.
- R9: The timer count is read and written as index 14 (high byte) and index 15 (low byte). While index 12 bit 7 is set, a tick occurs on every (divisor+1)-th cycle. The prescaler restarts while the timer is stopped, and the first tick comes after divisor+1 running cycles. Each tick decrements a nonzero count. A decrement from 1 to 0 sets bit 4 of index 8, and the count then stays at zero.
- R10: A host write-type access to index 14 or 15 takes precedence over a tick in the same cycle. The addressed byte of the current count is replaced by the merged value, no decrement occurs, and no expiry is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_addr | input | 9 | Area, mode and register index of the access |
| host_wdata | input | 8 | Data byte for write, AND and OR modes |
| host_rdata | output | 8 | Registered read data |
| adp_set_e | input | 8 | Adapter status set pulses for host status low |
| adp_set_o | input | 8 | Adapter status set pulses for host status high |
| adp_ack | input | 8 | Adapter acknowledge, clears doorbell request bits |
| db_req | output | 8 | Doorbell request bits presented to the adapter |
| db_ctl | output | 8 | Doorbell control byte presented to the adapter |
| host_irq | output | 1 | Host interrupt request |
| host_chck | output | 1 | Host channel-check signal |

## Verification
The bench builds the block with a non-default `NODE_ID` and `PAT_SEED`, so that the identification reads cannot match the defaults by accident. It keeps the 16-bit timer. The divisor is a run-time register, so divisors of 0 and 1 bring timer expiry within a few cycles. Loading tiny counts makes the 1-to-0 transition and the write-versus-tick collision easy to stage. Directed steps stage collisions between adapter events and host clears, and between acknowledges and host sets. A long random phase mixes every mode, area and index with adapter pulses.

// File: rtl/acr_pkg.sv
// Shared types and constants for the attachment control register block.
// Assumes a 9-bit host address: area[8:7], mode[6:5], index[4:0].
package acr_pkg;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 5;
    localparam int ADDR_W     = 9;
    localparam int REG_BASE   = 8;   // first control register index
    localparam int NUM_BREG   = 6;   // plain byte registers at 8..13
    localparam int IDX_TV_HI  = 14;
    localparam int IDX_TV_LO  = 15;

    localparam logic [7:0] HS_E_STAT = 8'h1C;  // status bits of host status low
    localparam logic [7:0] HS_O_STAT = 8'h7C;  // status bits of host status high
    localparam int HS_E_EN  = 6;
    localparam int HS_E_SEL = 7;
    localparam int TC_RUN   = 7;

    typedef enum logic [1:0] {
        OP_WR  = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_RD  = 2'b11
    } acr_op_e;

    typedef enum logic [1:0] {
        AR_CTL  = 2'b00,
        AR_RSV  = 2'b01,
        AR_NODE = 2'b10,
        AR_PAT  = 2'b11
    } acr_area_e;

    // Implemented-bit mask of byte register k (index REG_BASE+k).
    function automatic logic [7:0] reg_mask(input int k);
        case (k)
            0:       return 8'hDF;
            1:       return 8'h7C;
            2:       return 8'hFB;
            3:       return 8'h3F;
            4:       return 8'h80;
            5:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of register k that adapter-side events may set.
    function automatic logic [7:0] set_mask(input int k);
        case (k)
            0:       return HS_E_STAT;
            1:       return HS_O_STAT;
            default: return 8'h00;
        endcase
    endfunction

    // Merge a host data byte into an old value according to the mode.
    function automatic logic [7:0] apply_op(input acr_op_e op, input logic [7:0] old_v,
                                            input logic [7:0] d);
        case (op)
            OP_WR:   return d;
            OP_AND:  return old_v & d;
            OP_OR:   return old_v | d;
            default: return old_v;
        endcase
    endfunction
endpackage

// File: rtl/acr_decode.sv
// Address decoder: splits the host address into area, mode and index and
// classifies the access. Assumes one access per cycle qualified by sel_i.
module acr_decode
    import acr_pkg::*;
(
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acr_op_e           op_o,
    output acr_area_e         area_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic              reg_ok_o,
    output logic              bad_wr_o
);
    // Field split and access classification.
    always_comb begin
        op_o     = acr_op_e'(addr_i[6:5]);
        area_o   = acr_area_e'(addr_i[8:7]);
        idx_o    = addr_i[IDX_W-1:0];
        rd_o     = sel_i && (op_o == OP_RD);
        wr_o     = sel_i && (op_o != OP_RD);
        reg_ok_o = (area_o == AR_CTL) &&
                   (idx_o >= IDX_W'(REG_BASE)) && (idx_o <= IDX_W'(IDX_TV_LO));
        bad_wr_o = wr_o && !reg_ok_o;
    end
endmodule

// File: rtl/acr_reg_byte.sv
// One byte register with host write/AND/OR merge, adapter-side set and
// clear inputs. Clear acts before the host merge; set acts after it.
// Assumes SET_MASK is a subset of MASK.
module acr_reg_byte
    import acr_pkg::*;
#(
    parameter logic [7:0] MASK     = 8'hFF,
    parameter logic [7:0] SET_MASK = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  acr_op_e    op_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] set_i,
    input  logic [7:0] clr_i,
    output logic [7:0] q_o
);
    logic [7:0] base;
    logic [7:0] nxt;

    // Next value: acknowledge clear, then host merge, then event set.
    always_comb begin
        base = q_o & ~clr_i;
        nxt  = base;
        if (hit_i) nxt = apply_op(op_i, base, wdata_i) & MASK;
        nxt  = nxt | (set_i & SET_MASK);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

    // R4: an adapter event wins over any host merge of the same cycle.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & SET_MASK)) |=>
        ((q_o & $past(set_i & SET_MASK)) == $past(set_i & SET_MASK)));

    // R7: an acknowledge with no host access and no event clears the bits.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && |(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == 8'h00));
endmodule

// File: rtl/acr_timer.sv
// Interval timer: 8-bit prescaler and a TMR_W-bit down-counter that the
// host loads byte by byte. A host load outranks a tick of the same cycle.
// Assumes 9 <= TMR_W <= 16.
module acr_timer
    import acr_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [7:0]       div_i,
    input  logic             ld_hi_i,
    input  logic             ld_lo_i,
    input  acr_op_e          op_i,
    input  logic [7:0]       wdata_i,
    output logic [TMR_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam int HI_W = TMR_W - 8;

    logic [7:0]       pre;
    logic             tick;
    logic [7:0]       hi_cur;
    logic [7:0]       hi_new;
    logic [7:0]       lo_new;
    logic [TMR_W-1:0] cnt_nxt;

    // Tick when the prescaler reaches the divisor.
    always_comb tick = run_i && (pre == div_i);

    // Prescaler: restarts while stopped and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              pre <= '0;
        else if (!run_i || tick) pre <= '0;
        else                     pre <= pre + 8'd1;
    end

    // Next count: host byte load first, otherwise a tick decrement.
    always_comb begin
        hi_cur   = 8'(cnt_o >> 8);
        hi_new   = apply_op(op_i, hi_cur, wdata_i);
        lo_new   = apply_op(op_i, cnt_o[7:0], wdata_i);
        cnt_nxt  = cnt_o;
        expire_o = 1'b0;
        if (ld_hi_i)      cnt_nxt = {hi_new[HI_W-1:0], cnt_o[7:0]};
        else if (ld_lo_i) cnt_nxt = {cnt_o[TMR_W-1:8], lo_new};
        else if (tick && (cnt_o != '0)) begin
            cnt_nxt  = cnt_o - TMR_W'(1);
            expire_o = (cnt_o == TMR_W'(1));
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_nxt;
    end

    // R9: a stopped timer with no load keeps its count.
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !ld_hi_i && !ld_lo_i) |=> $stable(cnt_o));

    // R9: expiry leaves the count at zero.
    p_expire_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_o == '0));

    // R10: a low-byte load never lets a decrement borrow into the high byte.
    p_load_keeps_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo_i && !ld_hi_i) |=> (cnt_o[TMR_W-1:8] == $past(cnt_o[TMR_W-1:8])));
endmodule

// File: rtl/acr_id_rom.sv
// Read-only identification areas: node address bytes and a computed test
// pattern. Purely combinational; the caller registers the result.
module acr_id_rom
    import acr_pkg::*;
#(
    parameter logic [47:0] NODE_ID  = 48'h10005A3C7E21,
    parameter logic [7:0]  PAT_SEED = 8'hA5
) (
    input  acr_area_e        area_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       data_o
);
    localparam int NODE_BYTES = 6;
    localparam int ROM_SLOTS  = 8;

    logic [7:0] node_b [ROM_SLOTS];

    // Node address bytes, most significant first; spare slots read zero.
    for (genvar g = 0; g < ROM_SLOTS; g++) begin : g_node
        if (g < NODE_BYTES) begin : g_used
            assign node_b[g] = NODE_ID[(NODE_BYTES-1-g)*8 +: 8];
        end else begin : g_spare
            assign node_b[g] = 8'h00;
        end
    end

    // Area select between node bytes and the pattern.
    always_comb begin
        data_o = 8'h00;
        if (area_i == AR_NODE) begin
            if (idx_i[IDX_W-1:3] == '0) data_o = node_b[idx_i[2:0]];
        end else if (area_i == AR_PAT) begin
            data_o = PAT_SEED ^ {idx_i, 3'b000};
        end
    end
endmodule

// File: rtl/acr_regblock.sv
// Attachment control register block, top level. Decodes host accesses,
// holds host status, doorbell and timer registers, merges adapter events,
// drives the host interrupt and channel-check lines and registers reads.
// Assumes at most one host access per cycle.
module acr_regblock
    import acr_pkg::*;
#(
    parameter logic [47:0] NODE_ID  = 48'h10005A3C7E21,
    parameter logic [7:0]  PAT_SEED = 8'hA5,
    parameter int          TMR_W    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic [8:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] adp_set_e,
    input  logic [7:0] adp_set_o,
    input  logic [7:0] adp_ack,
    output logic [7:0] db_req,
    output logic [7:0] db_ctl,
    output logic       host_irq,
    output logic       host_chck
);
    acr_op_e           op;
    acr_area_e         area;
    logic [IDX_W-1:0]  idx;
    logic              wr, rd, reg_ok, bad_wr;
    logic [7:0]        q     [NUM_BREG];
    logic [7:0]        set_v [NUM_BREG];
    logic [7:0]        clr_v [NUM_BREG];
    logic [NUM_BREG-1:0] hit_v;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_exp;
    logic              pend;
    logic [7:0]        rom_val;
    logic [7:0]        rd_val;

    acr_decode u_dec (
        .sel_i(host_sel), .addr_i(host_addr), .op_o(op), .area_o(area),
        .idx_o(idx), .wr_o(wr), .rd_o(rd), .reg_ok_o(reg_ok), .bad_wr_o(bad_wr)
    );

    // Event routing: status sets, timer expiry, access error, acknowledges.
    always_comb begin
        for (int k = 0; k < NUM_BREG; k++) begin
            set_v[k] = 8'h00;
            clr_v[k] = 8'h00;
        end
        set_v[0] = (adp_set_e & HS_E_STAT) | {3'b000, tmr_exp, 1'b0, bad_wr, 2'b00};
        set_v[1] = adp_set_o;
        clr_v[3] = adp_ack;
    end

    for (genvar k = 0; k < NUM_BREG; k++) begin : g_reg
        assign hit_v[k] = wr && reg_ok && (idx == IDX_W'(REG_BASE + k));
        acr_reg_byte #(.MASK(reg_mask(k)), .SET_MASK(set_mask(k))) u_reg (
            .clk(clk), .rst_n(rst_n), .hit_i(hit_v[k]), .op_i(op),
            .wdata_i(host_wdata), .set_i(set_v[k]), .clr_i(clr_v[k]), .q_o(q[k])
        );
    end

    acr_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run_i(q[4][TC_RUN]), .div_i(q[5]),
        .ld_hi_i(wr && reg_ok && (idx == IDX_W'(IDX_TV_HI))),
        .ld_lo_i(wr && reg_ok && (idx == IDX_W'(IDX_TV_LO))),
        .op_i(op), .wdata_i(host_wdata), .cnt_o(tmr_cnt), .expire_o(tmr_exp)
    );

    acr_id_rom #(.NODE_ID(NODE_ID), .PAT_SEED(PAT_SEED)) u_rom (
        .area_i(area), .idx_i(idx), .data_o(rom_val)
    );

    // Interrupt lines: pending status gated by enable, steered by select.
    always_comb begin
        pend      = (|(q[0] & HS_E_STAT)) || (|(q[1] & HS_O_STAT));
        host_irq  = q[0][HS_E_EN] &&  q[0][HS_E_SEL] && pend;
        host_chck = q[0][HS_E_EN] && !q[0][HS_E_SEL] && pend;
    end

    // Read multiplexer over control registers, timer bytes and ROM areas.
    always_comb begin
        rd_val = 8'h00;
        if (area == AR_CTL) begin
            for (int k = 0; k < NUM_BREG; k++)
                if (idx == IDX_W'(REG_BASE + k)) rd_val = q[k];
            if (idx == IDX_W'(IDX_TV_HI)) rd_val = 8'(tmr_cnt >> 8);
            if (idx == IDX_W'(IDX_TV_LO)) rd_val = tmr_cnt[7:0];
        end else begin
            rd_val = rom_val;
        end
    end

    // Read data register, updated only by read accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)  host_rdata <= 8'h00;
        else if (rd) host_rdata <= rd_val;
    end

    assign db_req = q[3];
    assign db_ctl = q[2];

    // R6: with the enable bit clear neither line is raised.
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q[0][HS_E_EN] |-> (!host_irq && !host_chck));

    // R6: interrupt and channel check are never raised together.
    p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_irq && host_chck));

    // R5: an invalid write raises the access-error flag.
    p_bad_wr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> q[0][2]);

    // R8: reserved-area reads return zero.
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (area == AR_RSV)) |=> (host_rdata == 8'h00));

    // R8: read data holds between reads.
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(host_rdata));
endmodule

// File: tb/acr_regblock_tb_top.sv
// Bench for acr_regblock: behavioural reference model compared on every
// clock, plus directed checks against hand-computed values.
module acr_regblock_tb_top;
    localparam logic [47:0] TB_NODE = 48'h02608C123456;
    localparam logic [7:0]  TB_SEED = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic [8:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] adp_set_e = '0;
    logic [7:0] adp_set_o = '0;
    logic [7:0] adp_ack = '0;
    logic [7:0] db_req;
    logic [7:0] db_ctl;
    logic       host_irq;
    logic       host_chck;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    acr_regblock #(.NODE_ID(TB_NODE), .PAT_SEED(TB_SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .adp_set_e(adp_set_e),
        .adp_set_o(adp_set_o), .adp_ack(adp_ack), .db_req(db_req), .db_ctl(db_ctl),
        .host_irq(host_irq), .host_chck(host_chck)
    );

    // ---------------- reference model ----------------
    int m [32];
    int m_cnt, m_pre, m_rd;

    function automatic int mask_of(input int i);
        case (i)
            8: return 'hDF;  9: return 'h7C; 10: return 'hFB;
            11: return 'h3F; 12: return 'h80; 13: return 'hFF;
            default: return 0;
        endcase
    endfunction

    function automatic int apop(input int op, input int o, input int d);
        case (op)
            0: return d;
            1: return o & d;
            2: return o | d;
            default: return o;
        endcase
    endfunction

    function automatic int node_byte(input int i);
        logic [47:0] s;
        if (i >= 6) return 0;
        s = TB_NODE >> (8 * (5 - i));
        return int'(s[7:0]);
    endfunction

    function automatic int pat(input int i);
        return (int'(TB_SEED) ^ (i << 3)) & 255;
    endfunction

    always @(posedge clk) begin : model
        int op, ar, ix, wd, cn, pn;
        int n [32];
        bit wr, ok, tick, ex;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m[i] = 0;
            m_cnt = 0; m_pre = 0; m_rd = 0;
        end else begin
            op = int'(host_addr[6:5]); ar = int'(host_addr[8:7]);
            ix = int'(host_addr[4:0]); wd = int'(host_wdata);
            wr = host_sel && (op != 3);
            ok = (ar == 0) && (ix >= 8) && (ix <= 15);
            if ((m[12] & 128) != 0) begin
                tick = (m_pre == m[13]);
                pn = tick ? 0 : m_pre + 1;
            end else begin
                tick = 1'b0; pn = 0;
            end
            cn = m_cnt; ex = 1'b0;
            for (int i = 0; i < 32; i++) n[i] = m[i];
            n[11] = m[11] & ~int'(adp_ack) & 255;
            if (wr && ok && (ix == 14))
                cn = (apop(op, (m_cnt >> 8) & 255, wd) << 8) | (m_cnt & 255);
            else if (wr && ok && (ix == 15))
                cn = (m_cnt & 'hFF00) | apop(op, m_cnt & 255, wd);
            else if (tick && (m_cnt != 0)) begin
                cn = m_cnt - 1; ex = (m_cnt == 1);
            end
            if (wr && ok && (ix < 14)) n[ix] = apop(op, n[ix], wd) & mask_of(ix);
            if (wr && !ok) n[8] = n[8] | 4;
            if (ex) n[8] = n[8] | 16;
            n[8] = n[8] | (int'(adp_set_e) & 'h1C);
            n[9] = n[9] | (int'(adp_set_o) & 'h7C);
            if (host_sel && (op == 3)) begin
                if (ar == 0)      m_rd = !ok ? 0 : (ix == 14) ? ((m_cnt >> 8) & 255) :
                                         (ix == 15) ? (m_cnt & 255) : m[ix];
                else if (ar == 1) m_rd = 0;
                else if (ar == 2) m_rd = node_byte(ix);
                else              m_rd = pat(ix);
            end
            for (int i = 0; i < 32; i++) m[i] = n[i];
            m_cnt = cn; m_pre = pn;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of all outputs against the model.
    always @(negedge clk) begin
        bit pend, m_irq, m_chk;
        if (cmp_on && rst_n) begin
            pend  = ((m[8] & 'h1C) != 0) || ((m[9] & 'h7C) != 0);
            m_irq = ((m[8] & 64) != 0) && ((m[8] & 128) != 0) && pend;
            m_chk = ((m[8] & 64) != 0) && ((m[8] & 128) == 0) && pend;
            chk("R6 model host_irq", int'(host_irq), int'(m_irq));
            chk("R6 model host_chck", int'(host_chck), int'(m_chk));
            chk("R7 model db_req", int'(db_req), m[11]);
            chk("R3 model db_ctl", int'(db_ctl), m[10]);
            chk("R8 model host_rdata", int'(host_rdata), m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(input int area, input int op, input int idx, input int d);
        @(negedge clk);
        host_sel = 1'b1;
        host_addr = {2'(area), 2'(op), 5'(idx)};
        host_wdata = 8'(d);
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic rd(input int area, input int idx, output int d);
        acc(area, 3, idx, 0);
        d = int'(host_rdata);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 host_irq", int'(host_irq), 0);
        chk("R1 host_chck", int'(host_chck), 0);
        chk("R1 host_rdata", int'(host_rdata), 0);
        chk("R1 db_req", int'(db_req), 0);
        for (int i = 8; i <= 15; i++) begin
            rd(0, i, v);
            chk("R1 register after reset", v, 0);
        end

        // R2: write, AND, OR modes on the divisor register
        acc(0, 0, 13, 'hF0);
        acc(0, 1, 13, 'h3C);
        rd(0, 13, v); chk("R2 AND merge", v, 'h30);
        acc(0, 2, 13, 'h05);
        rd(0, 13, v); chk("R2 OR merge", v, 'h35);

        // R3: implemented-bit masks
        acc(0, 0, 9, 'hFF);  rd(0, 9, v);  chk("R3 mask index 9", v, 'h7C);
        acc(0, 0, 10, 'hFF); rd(0, 10, v); chk("R3 mask index 10", v, 'hFB);
        chk("R3 db_ctl", int'(db_ctl), 'hFB);
        acc(0, 0, 8, 'hFF);  rd(0, 8, v);  chk("R3 mask index 8", v, 'hDF);
        acc(0, 0, 8, 0); acc(0, 0, 9, 0); acc(0, 0, 10, 0);

        // R4: event sets a bit; event wins over same-cycle AND-clear
        @(negedge clk); adp_set_o = 'h20; adp_set_e = 'h08;
        @(negedge clk); adp_set_o = 0; adp_set_e = 0;
        rd(0, 9, v); chk("R4 event sets index 9", v, 'h20);
        rd(0, 8, v); chk("R4 event sets index 8", v, 'h08);
        @(negedge clk);
        host_sel = 1'b1; host_addr = {2'd0, 2'd1, 5'd9}; host_wdata = 8'h00;
        adp_set_o = 'h08;
        @(negedge clk); host_sel = 1'b0; adp_set_o = 0;
        rd(0, 9, v); chk("R4 set beats AND-clear", v, 'h08);
        acc(0, 0, 8, 0); acc(0, 0, 9, 0);

        // R5: invalid writes flag an access error and change nothing else
        acc(0, 0, 3, 'hFF);
        rd(0, 8, v); chk("R5 error flag, unused index", v, 'h04);
        rd(0, 13, v); chk("R5 divisor untouched", v, 'h35);
        acc(0, 0, 8, 0);
        acc(2, 2, 13, 'hFF);
        rd(0, 8, v); chk("R5 error flag, node area write", v, 'h04);
        rd(0, 13, v); chk("R5 divisor untouched again", v, 'h35);
        acc(0, 0, 8, 0);

        // R6: interrupt steering and enable
        acc(0, 0, 9, 'h08);
        chk("R6 disabled irq", int'(host_irq), 0);
        acc(0, 0, 8, 'hC0);
        chk("R6 irq raised", int'(host_irq), 1);
        chk("R6 chck low", int'(host_chck), 0);
        acc(0, 1, 8, 'h7F);
        chk("R6 chck raised", int'(host_chck), 1);
        chk("R6 irq low", int'(host_irq), 0);
        acc(0, 0, 8, 0); acc(0, 0, 9, 0);
        chk("R6 nothing pending", int'(host_chck), 0);

        // R7: doorbell set, acknowledge, collision
        acc(0, 2, 11, 'h30);
        chk("R7 doorbell set", int'(db_req), 'h30);
        @(negedge clk); adp_ack = 'h10;
        @(negedge clk); adp_ack = 0;
        chk("R7 ack clears", int'(db_req), 'h20);
        @(negedge clk);
        host_sel = 1'b1; host_addr = {2'd0, 2'd2, 5'd11}; host_wdata = 8'h20;
        adp_ack = 'h20;
        @(negedge clk); host_sel = 1'b0; adp_ack = 0;
        chk("R7 host set beats ack", int'(db_req), 'h20);

        // R8: identification and reserved areas
        rd(1, 9, v); chk("R8 reserved area", v, 0);
        for (int i = 0; i < 6; i++) begin
            rd(2, i, v); chk("R8 node byte", v, node_byte(i));
        end
        rd(2, 7, v); chk("R8 node spare", v, 0);
        rd(3, 4, v); chk("R8 pattern", v, pat(4));
        rd(3, 31, v); chk("R8 pattern top", v, pat(31));
        rd(0, 20, v); chk("R8 unused index", v, 0);

        // R9: expiry with divisor 1 and count 3
        acc(0, 0, 13, 1); acc(0, 0, 14, 0); acc(0, 0, 15, 3);
        acc(0, 0, 12, 'h80);
        repeat (20) @(negedge clk);
        rd(0, 8, v); chk("R9 expiry flag", v, 'h10);
        rd(0, 15, v); chk("R9 count stays zero", v, 0);
        acc(0, 0, 12, 0); acc(0, 0, 8, 0);

        // R10: load beats tick in the same cycle (divisor 0)
        acc(0, 0, 13, 0); acc(0, 0, 15, 5);
        acc(0, 0, 12, 'h80);
        acc(0, 0, 15, 9);
        acc(0, 0, 12, 0);
        rd(0, 15, v); chk("R10 low byte after collision", v, 7);
        rd(0, 14, v); chk("R10 high byte after collision", v, 0);
        rd(0, 8, v);  chk("R10 no expiry", v, 0);

        // Random traffic against the model (R2..R10)
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            host_sel   = ($urandom % 3) != 0;
            host_addr[8:7] = (($urandom % 8) == 0) ? 2'($urandom) : 2'd0;
            host_addr[6:5] = 2'($urandom);
            host_addr[4:0] = (($urandom % 6) == 0) ? 5'($urandom) : 5'(8 + $urandom % 8);
            host_wdata = 8'($urandom);
            adp_set_e  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            adp_set_o  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            adp_ack    = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
        end
        @(negedge clk);
        host_sel = 0; adp_set_e = 0; adp_set_o = 0; adp_ack = 0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule